// File: doc/BRIEF.md
# Session Receive Buffer with Commit and Rollback

This block stores bytes that arrive while a packet is still being received, before anyone knows whether the packet is good. Each byte is written with a source and a destination address. Every four bytes are packed into one 32-bit word and placed in a word store, but the reader cannot see them yet. A commit pulse publishes every complete word written since the last commit or drop. A drop pulse rolls the speculative write pointer back, so those words vanish as if they had never been written.

On the read side a flag shows that at least one published word is unread. A one-cycle read pulse loads the oldest word and its two addresses onto the outputs, where they stay until the next read pulse. The reader must check the flag first. A read pulse while nothing is published does nothing.

Top module: `session_fifo`

## Requirements
- R1: The four bytes of a word are packed first-in into bits 31:24 and last-in into bits 7:0. The source and destination addresses stored with the word are the ones given with its fourth byte.
- R2: A `sess_end` pulse makes the words written in the session readable. `new_data` is high from the clock edge after the pulse.
- R3: A `sess_drop` pulse removes every word written since the last commit or drop. Words published earlier are not affected.
- R4: Bytes of an incomplete word are dropped at a commit or drop. The next byte written starts a new word at bits 31:24.
- R5: The store holds `DEPTH` (8) words, counting both published and speculative ones. `full` is high exactly when all of them are taken.
- R6: A byte written while `full` is high is ignored. Its session is then rolled back at its next `sess_end`, as if `sess_drop` had been given.
- R7: A `rd_en` pulse while `new_data` is high loads the oldest published word and its addresses onto `rd_word`/`rd_src`/`rd_dst` at the next edge. They hold until the next accepted read, and words come out in the order they were written.
- R8: A `rd_en` pulse while `new_data` is low leaves the outputs and the read position unchanged.
- R9: After reset `new_data` and `full` are 0 and the read outputs are 0.
- R10: A byte written in the same cycle as `sess_end` or `sess_drop` is ignored. When `sess_end` and `sess_drop` arrive together, the drop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one byte this cycle |
| wr_byte | input | 8 | Byte to store |
| wr_src | input | 8 | Source address given with the byte |
| wr_dst | input | 8 | Destination address given with the byte |
| sess_end | input | 1 | Publish the current session |
| sess_drop | input | 1 | Roll back the current session |
| rd_en | input | 1 | Read the oldest published word |
| rd_word | output | 32 | Word last read |
| rd_src | output | 8 | Source address of `rd_word` |
| rd_dst | output | 8 | Destination address of `rd_word` |
| new_data | output | 1 | At least one published word is unread |
| full | output | 1 | No word space left |

## Verification
The bench targets a full store made only of speculative words. A design that counted only published words would keep accepting bytes and overwrite unread data. It also fills the store with eight published words and then sends one more session. A design that did not poison that session would publish a ninth word on top of the first. Partial words at commit are covered, together with a byte arriving in the same cycle as a commit. A wrong byte counter would shift every later word by one byte. A simultaneous commit and drop is also checked, and a design that let the commit win would publish data it should have rolled back. A read pulse on an empty store is included, and a design that advanced the read pointer there would lose the next word.

// File: rtl/session_fifo.sv
module session_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  input  logic [AW-1:0] wr_src,
  input  logic [AW-1:0] wr_dst,
  input  logic          sess_end,
  input  logic          sess_drop,
  input  logic          rd_en,
  output logic [31:0]   rd_word,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst,
  output logic          new_data,
  output logic          full
);
  localparam int PW = $clog2(DEPTH);

  logic [31:0]   mem_w [DEPTH];
  logic [AW-1:0] mem_s [DEPTH];
  logic [AW-1:0] mem_d [DEPTH];

  logic [PW:0] wp_com, wp_spec, rp;
  logic [23:0] acc;
  logic [1:0]  nbytes;
  logic        poison;

  wire [PW:0] used   = wp_spec - rp;
  assign full        = used == (PW+1)'(DEPTH);
  assign new_data    = wp_com != rp;

  wire take   = wr_en && !sess_end && !sess_drop && !full;
  wire mem_we = take && nbytes == 2'd3;
  wire rd_ok  = rd_en && new_data;

  always_ff @(posedge clk)
    if (mem_we) begin
      mem_w[wp_spec[PW-1:0]] <= {acc, wr_byte};
      mem_s[wp_spec[PW-1:0]] <= wr_src;
      mem_d[wp_spec[PW-1:0]] <= wr_dst;
    end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_com  <= '0;
      wp_spec <= '0;
      rp      <= '0;
      acc     <= '0;
      nbytes  <= '0;
      poison  <= 1'b0;
      rd_word <= '0;
      rd_src  <= '0;
      rd_dst  <= '0;
    end else begin
      if (sess_drop || (sess_end && poison)) begin
        wp_spec <= wp_com;
        nbytes  <= '0;
        poison  <= 1'b0;
      end else if (sess_end) begin
        wp_com  <= wp_spec;
        nbytes  <= '0;
      end else if (wr_en) begin
        if (full) poison <= 1'b1;
        else if (mem_we) begin
          wp_spec <= wp_spec + 1'b1;
          nbytes  <= '0;
        end else begin
          acc    <= {acc[15:0], wr_byte};
          nbytes <= nbytes + 1'b1;
        end
      end
      if (rd_ok) begin
        rd_word <= mem_w[rp[PW-1:0]];
        rd_src  <= mem_s[rp[PW-1:0]];
        rd_dst  <= mem_d[rp[PW-1:0]];
        rp      <= rp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/session_fifo_chk.sv
module session_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  parameter int PW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          sess_end,
  input logic          sess_drop,
  input logic          new_data,
  input logic          poison,
  input logic [31:0]   rd_word,
  input logic [AW-1:0] rd_src,
  input logic [PW:0]   wp_com,
  input logic [PW:0]   wp_spec,
  input logic [PW:0]   rp
);
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (PW+1)'(wp_spec - rp) <= (PW+1)'(DEPTH));
  a_r2_new_after_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(new_data) |-> $past(sess_end));
  a_r3_drop_rewinds: assert property (@(posedge clk) disable iff (rst)
    sess_drop |=> wp_spec == $past(wp_com));
  a_r2_commit_publishes: assert property (@(posedge clk) disable iff (rst)
    (sess_end && !sess_drop && !poison) |=> wp_com == $past(wp_spec));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_word) && $stable(rd_src));
  a_r8_empty_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !new_data) |=> $stable(rp) && $stable(rd_word));
endmodule

bind session_fifo session_fifo_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .sess_end(sess_end), .sess_drop(sess_drop),
  .new_data(new_data), .poison(poison), .rd_word(rd_word), .rd_src(rd_src),
  .wp_com(wp_com), .wp_spec(wp_spec), .rp(rp)
);

// File: tb/session_fifo_tb.sv
`timescale 1ns/1ps
module session_fifo_tb;
  logic clk = 0, rst = 1;
  logic wr_en = 0, sess_end = 0, sess_drop = 0, rd_en = 0;
  logic [7:0] wr_byte = 0, wr_src = 0, wr_dst = 0;
  logic [31:0] rd_word;
  logic [7:0] rd_src, rd_dst;
  logic new_data, full;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  session_fifo u_dut (.*);

  // {commit, word, src, dst}
  localparam logic [48:0] VEC [6] = '{
    {1'b1, 32'h11223344, 8'h01, 8'h02},
    {1'b0, 32'hDEADBEEF, 8'h03, 8'h04},
    {1'b1, 32'hA5A55A5A, 8'h05, 8'hFF},
    {1'b1, 32'h00000001, 8'h07, 8'h08},
    {1'b0, 32'hCAFEF00D, 8'h09, 8'h0A},
    {1'b1, 32'h80000000, 8'h0B, 8'h0C}
  };

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b, logic [7:0] s, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_byte = b; wr_src = s; wr_dst = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic put_word(logic [31:0] w, logic [7:0] s, logic [7:0] d);
    put(w[31:24], 8'hEE, 8'hEE);
    put(w[23:16], 8'hEE, 8'hEE);
    put(w[15:8],  8'hEE, 8'hEE);
    put(w[7:0],   s, d);
  endtask

  task automatic pulse(logic e, logic dr);
    @(negedge clk); sess_end = e; sess_drop = dr;
    @(negedge clk); sess_end = 0; sess_drop = 0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset flags", {46'd0, new_data, full}, 48'd0);
    chk("R9 reset outputs", {rd_word, rd_src, rd_dst}, 48'd0);
    rst = 0;

    // table walk: R1 R2 R3 R7
    foreach (VEC[i]) begin
      put_word(VEC[i][47:16], VEC[i][15:8], VEC[i][7:0]);
      pulse(VEC[i][48], !VEC[i][48]);
      if (VEC[i][48]) chk("R2 new_data after commit", {47'd0, new_data}, 48'd1);
    end
    foreach (VEC[i]) begin
      if (VEC[i][48]) begin
        rd();
        chk("R1 R3 R7 word and addresses", {rd_word, rd_src, rd_dst}, VEC[i][47:0]);
      end
    end
    chk("R3 nothing left after drops", {47'd0, new_data}, 48'd0);

    // R8: read while empty
    rd();
    chk("R8 empty read holds", {rd_word, rd_src, rd_dst}, VEC[5][47:0]);

    // R4: partial word dropped at commit
    put(8'h99, 8'h01, 8'h01); put(8'h98, 8'h01, 8'h01);
    pulse(1, 0);
    chk("R4 partial not published", {47'd0, new_data}, 48'd0);
    put_word(32'h0A0B0C0D, 8'h21, 8'h22);
    pulse(1, 0);
    rd();
    chk("R4 next word aligned", {rd_word, rd_src, rd_dst}, {32'h0A0B0C0D, 8'h21, 8'h22});
    chk("R8 prior word intact after empty read", {47'd0, new_data}, 48'd0);

    // R10: byte together with commit ignored
    put(8'h01, 8'h00, 8'h00); put(8'h02, 8'h00, 8'h00); put(8'h03, 8'h00, 8'h00);
    @(negedge clk); wr_en = 1; wr_byte = 8'h04; sess_end = 1;
    @(negedge clk); wr_en = 0; sess_end = 0;
    chk("R10 byte with commit ignored", {47'd0, new_data}, 48'd0);
    put_word(32'h55667788, 8'h31, 8'h32);
    pulse(1, 1);
    chk("R10 drop wins over commit", {47'd0, new_data}, 48'd0);
    put_word(32'h13572468, 8'h41, 8'h42);
    pulse(1, 0);
    rd();
    chk("R10 later word clean", {rd_word, rd_src, rd_dst}, {32'h13572468, 8'h41, 8'h42});

    // R5: speculative words fill the store
    for (int k = 0; k < 8; k++) put_word(32'h100 + k, 8'h50, 8'h60);
    chk("R5 full from speculative words", {46'd0, full, new_data}, {46'd0, 2'b10});
    put_word(32'hBAD0BAD0, 8'h66, 8'h66);
    pulse(1, 0);
    chk("R6 poisoned session rolled back", {46'd0, full, new_data}, 48'd0);

    // R5 R6: published words fill the store, extra session lost
    for (int k = 0; k < 7; k++) put_word(32'h200 + k, 8'h70 + 8'(k), 8'h80);
    pulse(1, 0);
    chk("R5 not full at seven", {47'd0, full}, 48'd0);
    put_word(32'h207, 8'h77, 8'h80);
    pulse(1, 0);
    chk("R5 full at eight", {47'd0, full}, 48'd1);
    put_word(32'hFFFF0000, 8'h99, 8'h99);
    pulse(1, 0);
    for (int k = 0; k < 8; k++) begin
      rd();
      chk("R6 R7 stored order", {rd_word, rd_src, rd_dst}, {32'h200 + k, 8'h70 + 8'(k), 8'h80});
    end
    chk("R6 extra session absent", {46'd0, full, new_data}, 48'd0);

    finish_run();
  end
endmodule